// File: doc/BRIEF.md
# QoS and Round-Robin Link Channel Arbiter

This block chooses which channel gets the next word on a shared serial link. It has two arbiters, one for each link direction. The forward arbiter serves three request channels: write data, write address and read address. It grants the eligible channel with the highest quality-of-service (QoS) value. The address channels compete with the QoS value that arrives with each request. A write-data channel cannot carry its own QoS value, so it competes with the value saved from the write address it belongs to. These saved values are kept in order in a small queue. An entry is added when an address beat completes and removed when the closing data beat completes.

The reverse arbiter serves a parameterised number of response channels in round-robin order. Its search pointer moves past a channel only once that channel's beat has completed.

Each beat may take several link words. In both directions the grant locks onto one channel. It stays there while the link is not ready, and it stays there until the last word of the beat has been accepted. A channel drives its request bit only while it is valid and holds credit; credit accounting and packing happen outside this block.

Top module: `chan_link_arbiter`

## Requirements
- R1: `fwd_gnt_o` has at most one bit set, and only for a requesting channel. The channel bit positions are: bit 0 write data, bit 1 write address, bit 2 read address.
- R2: When both address channels are eligible, the one with the larger QoS value (`aw_qos_i` or `ar_qos_i`) is granted.
- R3: A write-data request competes with the saved write-address QoS at the head of the queue. Entries leave the queue in arrival order, and an entry is removed only on a write-data beat completed with `w_burst_last_i` high.
- R4: Equal QoS values are resolved by fixed rank: write data first, then write address, then read address.
- R5: A write-data request is ignored while the queue is empty. A write-address request is ignored while the queue holds `WQ_DEPTH` entries; a lower-QoS channel may then win.
- R6: In either direction, a grant issued while the link is not ready stays unchanged in the following cycle.
- R7: A word accepted without its channel's word-last bit keeps the grant on that channel in the next cycle, whatever the other requests are.
- R8: When a reverse beat completes on channel i, the next reverse search starts at channel i+1, wrapping to 0 after N_REV-1. An incomplete beat does not move the pointer.
- R9: After reset both grants are zero, the reverse pointer is at channel 0 and the queue is empty. With no requests, the grants stay zero.
- R10: `rev_gnt_o` has at most one bit set, and only for a requesting channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fwd_req_i | input | 3 | Forward requests (bit 0 W, bit 1 AW, bit 2 AR) |
| aw_qos_i | input | QOS_W | QoS of the pending write address |
| ar_qos_i | input | QOS_W | QoS of the pending read address |
| fwd_word_last_i | input | 3 | Per forward channel: the current word ends its beat |
| w_burst_last_i | input | 1 | The current write-data beat closes its transaction |
| fwd_link_rdy_i | input | 1 | Forward link accepts a word this cycle |
| fwd_gnt_o | output | 3 | One-hot forward grant |
| rev_req_i | input | N_REV | Reverse channel requests |
| rev_word_last_i | input | N_REV | Per reverse channel: the current word ends its beat |
| rev_link_rdy_i | input | 1 | Reverse link accepts a word this cycle |
| rev_gnt_o | output | N_REV | One-hot reverse grant |

## Verification
Two functions can act in the same cycle: the QoS selection and the grant lock. A higher-QoS address request can arrive while a read-address beat is waiting for a busy link, or while it is partway through its words. The bench raises that request in exactly those cycles. It judges the cycle correct only if the grant stays on the earlier channel. The queue limit also meets the QoS selection: a full queue with a high-QoS write address pending must hand the grant to a lower-QoS write-data request.

// File: rtl/chan_arb_pkg.sv
package chan_arb_pkg;
  localparam int N_FWD = 3;
  localparam int CH_W  = 0;
  localparam int CH_AW = 1;
  localparam int CH_AR = 2;
  localparam int RANK_W = 2;
endpackage

// File: rtl/qos_store.sv
module qos_store #(
  parameter int QOS_W = 4,
  parameter int DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [QOS_W-1:0] push_qos_i,
  input  logic             pop_i,
  output logic [QOS_W-1:0] head_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [QOS_W-1:0] mem_q [DEPTH];
  logic [PW-1:0]    wr_q, rd_q;
  logic [CW-1:0]    cnt_q;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign head_o  = mem_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (push_i && !full_o) mem_q[wr_q] <= push_qos_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i && !full_o)
        wr_q <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (pop_i && !empty_o)
        rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      case ({push_i && !full_o, pop_i && !empty_o})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/fwd_qos_pick.sv
module fwd_qos_pick
  import chan_arb_pkg::*;
#(
  parameter int QOS_W = 4
) (
  input  logic [N_FWD-1:0]            elig_i,
  input  logic [N_FWD-1:0][QOS_W-1:0] qos_i,
  output logic [N_FWD-1:0]            pick_o
);
  localparam int SW = QOS_W + RANK_W;

  logic [SW-1:0] best;
  logic [SW-1:0] score;
  logic          found;

  // lower channel index ranks higher on equal QoS
  always_comb begin
    pick_o = '0;
    best   = '0;
    found  = 1'b0;
    for (int i = 0; i < N_FWD; i++) begin
      score = {qos_i[i], RANK_W'(N_FWD - 1 - i)};
      if (elig_i[i] && (!found || score > best)) begin
        best   = score;
        pick_o = '0;
        pick_o[i] = 1'b1;
        found  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int N = 4,
  localparam int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [PW-1:0] ptr_i,
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  pick_o
);
  int   idx;
  logic found;

  always_comb begin
    pick_o = '0;
    found  = 1'b0;
    idx    = 0;
    for (int i = 0; i < N; i++) begin
      idx = int'(ptr_i) + i;
      if (idx >= N) idx = idx - N;
      if (!found && req_i[idx]) begin
        pick_o[idx] = 1'b1;
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/grant_hold.sv
module grant_hold #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pick_i,
  input  logic [N-1:0] word_last_i,
  input  logic         link_rdy_i,
  output logic [N-1:0] gnt_o,
  output logic         done_o
);
  logic         lock_q;
  logic [N-1:0] held_q;

  assign gnt_o  = lock_q ? held_q : pick_i;
  assign done_o = link_rdy_i && |(gnt_o & word_last_i);

  // lock until the beat's last word is taken
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b0;
      held_q <= '0;
    end else begin
      lock_q <= |gnt_o && !done_o;
      held_q <= gnt_o;
    end
  end
endmodule

// File: rtl/chan_link_arbiter.sv
module chan_link_arbiter
  import chan_arb_pkg::*;
#(
  parameter int QOS_W    = 4,
  parameter int WQ_DEPTH = 4,
  parameter int N_REV    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       fwd_req_i,
  input  logic [QOS_W-1:0] aw_qos_i,
  input  logic [QOS_W-1:0] ar_qos_i,
  input  logic [2:0]       fwd_word_last_i,
  input  logic             w_burst_last_i,
  input  logic             fwd_link_rdy_i,
  output logic [2:0]       fwd_gnt_o,
  input  logic [N_REV-1:0] rev_req_i,
  input  logic [N_REV-1:0] rev_word_last_i,
  input  logic             rev_link_rdy_i,
  output logic [N_REV-1:0] rev_gnt_o
);
  localparam int PW = (N_REV > 1) ? $clog2(N_REV) : 1;

  // forward direction
  logic [QOS_W-1:0]            st_head;
  logic                        st_empty, st_full;
  logic                        fwd_done;
  logic [N_FWD-1:0]            fwd_elig, fwd_pick;
  logic [N_FWD-1:0][QOS_W-1:0] fwd_qos;

  always_comb begin
    fwd_elig        = fwd_req_i;
    fwd_elig[CH_W]  = fwd_req_i[CH_W] && !st_empty;
    fwd_elig[CH_AW] = fwd_req_i[CH_AW] && !st_full;
    fwd_qos[CH_W]   = st_head;
    fwd_qos[CH_AW]  = aw_qos_i;
    fwd_qos[CH_AR]  = ar_qos_i;
  end

  qos_store #(.QOS_W(QOS_W), .DEPTH(WQ_DEPTH)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (fwd_done && fwd_gnt_o[CH_AW]),
    .push_qos_i (aw_qos_i),
    .pop_i      (fwd_done && fwd_gnt_o[CH_W] && w_burst_last_i),
    .head_o     (st_head),
    .empty_o    (st_empty),
    .full_o     (st_full)
  );

  fwd_qos_pick #(.QOS_W(QOS_W)) u_fwd_pick (
    .elig_i (fwd_elig),
    .qos_i  (fwd_qos),
    .pick_o (fwd_pick)
  );

  grant_hold #(.N(N_FWD)) u_fwd_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pick_i      (fwd_pick),
    .word_last_i (fwd_word_last_i),
    .link_rdy_i  (fwd_link_rdy_i),
    .gnt_o       (fwd_gnt_o),
    .done_o      (fwd_done)
  );

  // reverse direction
  logic [PW-1:0]    ptr_q, rev_idx;
  logic [N_REV-1:0] rev_pick;
  logic             rev_done;

  rr_pick #(.N(N_REV)) u_rr (
    .ptr_i  (ptr_q),
    .req_i  (rev_req_i),
    .pick_o (rev_pick)
  );

  grant_hold #(.N(N_REV)) u_rev_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pick_i      (rev_pick),
    .word_last_i (rev_word_last_i),
    .link_rdy_i  (rev_link_rdy_i),
    .gnt_o       (rev_gnt_o),
    .done_o      (rev_done)
  );

  always_comb begin
    rev_idx = '0;
    for (int i = 0; i < N_REV; i++)
      if (rev_gnt_o[i]) rev_idx = PW'(i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      ptr_q <= '0;
    else if (rev_done)
      ptr_q <= (rev_idx == PW'(N_REV - 1)) ? '0 : rev_idx + 1'b1;
  end
endmodule

// File: rtl/chan_link_arbiter_chk.sv
module chan_link_arbiter_chk #(
  parameter int QOS_W    = 4,
  parameter int WQ_DEPTH = 4,
  parameter int N_REV    = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       fwd_req_i,
  input logic [QOS_W-1:0] aw_qos_i,
  input logic [QOS_W-1:0] ar_qos_i,
  input logic [2:0]       fwd_word_last_i,
  input logic             w_burst_last_i,
  input logic             fwd_link_rdy_i,
  input logic [2:0]       fwd_gnt_o,
  input logic [N_REV-1:0] rev_req_i,
  input logic [N_REV-1:0] rev_word_last_i,
  input logic             rev_link_rdy_i,
  input logic [N_REV-1:0] rev_gnt_o
);
  localparam int CW = $clog2(WQ_DEPTH + 1) + 1;

  logic [CW-1:0] open_cnt;
  logic          fwd_end, rev_end;

  assign fwd_end = fwd_link_rdy_i && |(fwd_gnt_o & fwd_word_last_i);
  assign rev_end = rev_link_rdy_i && |(rev_gnt_o & rev_word_last_i);

  // independent count of addresses awaiting their closing data beat
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      open_cnt <= '0;
    else if (fwd_end && fwd_gnt_o[1])
      open_cnt <= open_cnt + 1'b1;
    else if (fwd_end && fwd_gnt_o[0] && w_burst_last_i)
      open_cnt <= open_cnt - 1'b1;
  end

  AST_FWD_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(fwd_gnt_o) && ((fwd_gnt_o & ~fwd_req_i) == '0)); // R1

  AST_REV_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rev_gnt_o) && ((rev_gnt_o & ~rev_req_i) == '0)); // R10

  AST_FWD_WAIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|fwd_gnt_o && !fwd_link_rdy_i) |=> fwd_gnt_o == $past(fwd_gnt_o)); // R6

  AST_REV_WAIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rev_gnt_o && !rev_link_rdy_i) |=> rev_gnt_o == $past(rev_gnt_o)); // R6

  AST_FWD_BEAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|fwd_gnt_o && fwd_link_rdy_i && !fwd_end) |=> fwd_gnt_o == $past(fwd_gnt_o)); // R7

  AST_REV_BEAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rev_gnt_o && rev_link_rdy_i && !rev_end) |=> rev_gnt_o == $past(rev_gnt_o)); // R7

  AST_W_HAS_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_gnt_o[0] |-> open_cnt != '0); // R5

  AST_AW_HAS_ROOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_gnt_o[1] |-> open_cnt < CW'(WQ_DEPTH)); // R5
endmodule

bind chan_link_arbiter chan_link_arbiter_chk #(
  .QOS_W(QOS_W), .WQ_DEPTH(WQ_DEPTH), .N_REV(N_REV)
) u_chk (.*);

// File: tb/chan_link_arbiter_test.sv
`timescale 1ns/1ps
module chan_link_arbiter_test;
  localparam int QOS_W = 4;
  localparam int WQ_DEPTH = 4;
  localparam int N_REV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] fwd_req = '0, fwd_wl = '0, fwd_gnt;
  logic [QOS_W-1:0] awq = '0, arq = '0;
  logic w_bl = 1'b0, fwd_rdy = 1'b0;
  logic [N_REV-1:0] rev_req = '0, rev_wl = '0, rev_gnt;
  logic rev_rdy = 1'b0;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  chan_link_arbiter #(.QOS_W(QOS_W), .WQ_DEPTH(WQ_DEPTH), .N_REV(N_REV)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .fwd_req_i(fwd_req), .aw_qos_i(awq), .ar_qos_i(arq),
    .fwd_word_last_i(fwd_wl), .w_burst_last_i(w_bl), .fwd_link_rdy_i(fwd_rdy),
    .fwd_gnt_o(fwd_gnt),
    .rev_req_i(rev_req), .rev_word_last_i(rev_wl), .rev_link_rdy_i(rev_rdy),
    .rev_gnt_o(rev_gnt)
  );

  typedef struct packed {
    logic [2:0]       req;
    logic [QOS_W-1:0] aw;
    logic [QOS_W-1:0] ar;
    logic             bl;
    logic [2:0]       exp;
  } vec_t;

  // each vector completes a one-word beat; queue contents tracked in comments
  localparam vec_t VECS [13] = '{
    '{3'b110, 4'd3,  4'd5,  1'b0, 3'b100}, // AR wins            []
    '{3'b110, 4'd7,  4'd2,  1'b0, 3'b010}, // AW wins            [7]
    '{3'b110, 4'd4,  4'd4,  1'b0, 3'b010}, // tie AW over AR     [7,4]
    '{3'b111, 4'd9,  4'd8,  1'b0, 3'b010}, // AW 9 beats W 7     [7,4,9]
    '{3'b101, 4'd0,  4'd7,  1'b1, 3'b001}, // tie W over AR      [4,9]
    '{3'b101, 4'd0,  4'd5,  1'b0, 3'b100}, // AR 5 beats W 4
    '{3'b111, 4'd4,  4'd3,  1'b0, 3'b001}, // tie W, no pop
    '{3'b111, 4'd2,  4'd3,  1'b1, 3'b001}, // W 4 wins, pop      [9]
    '{3'b101, 4'd0,  4'd15, 1'b0, 3'b100}, // AR 15 beats W 9
    '{3'b001, 4'd0,  4'd0,  1'b1, 3'b001}, // W alone, pop       []
    '{3'b001, 4'd0,  4'd0,  1'b0, 3'b000}, // W, empty queue
    '{3'b011, 4'd0,  4'd0,  1'b0, 3'b010}, // AW only eligible   [0]
    '{3'b101, 4'd0,  4'd0,  1'b1, 3'b001}  // tie W over AR      []
  };

  task automatic check(input logic [3:0] act, input logic [3:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic fwd(input logic [2:0] req, input logic [3:0] aw, input logic [3:0] ar,
                     input logic [2:0] wl, input logic bl, input logic rdy);
    @(negedge clk);
    fwd_req = req; awq = aw; arq = ar; fwd_wl = wl; w_bl = bl; fwd_rdy = rdy;
    #1;
  endtask

  task automatic rev(input logic [3:0] req, input logic [3:0] wl, input logic rdy);
    @(negedge clk);
    rev_req = req; rev_wl = wl; rev_rdy = rdy;
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R1 act=timeout exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    check({1'b0, fwd_gnt}, 4'b0000, "R9 fwd reset grant");
    check(rev_gnt, 4'b0000, "R9 rev reset grant");

    // table: R2 R3 R4 R5
    foreach (VECS[i]) begin
      fwd(VECS[i].req, VECS[i].aw, VECS[i].ar, 3'b111, VECS[i].bl, 1'b1);
      check({1'b0, fwd_gnt}, {1'b0, VECS[i].exp}, $sformatf("R2/R3/R4 vector %0d", i));
    end
    fwd(3'b000, 0, 0, 3'b111, 1'b0, 1'b1);
    check({1'b0, fwd_gnt}, 4'b0000, "R9 idle fwd");

    // R5: fill the queue, then AW blocked
    for (int i = 0; i < WQ_DEPTH; i++) begin
      fwd(3'b010, 4'd1, 0, 3'b111, 1'b0, 1'b1);
      check({1'b0, fwd_gnt}, 4'b0010, "R5 AW fill");
    end
    fwd(3'b010, 4'd1, 0, 3'b111, 1'b0, 1'b1);
    check({1'b0, fwd_gnt}, 4'b0000, "R5 AW blocked full");
    fwd(3'b011, 4'd15, 0, 3'b111, 1'b1, 1'b1);
    check({1'b0, fwd_gnt}, 4'b0001, "R5 low W wins over full-blocked AW");
    for (int i = 0; i < WQ_DEPTH - 1; i++) begin
      fwd(3'b001, 0, 0, 3'b111, 1'b1, 1'b1);
      check({1'b0, fwd_gnt}, 4'b0001, "R3 drain");
    end
    fwd(3'b001, 0, 0, 3'b111, 1'b1, 1'b1);
    check({1'b0, fwd_gnt}, 4'b0000, "R5 W ignored when drained");

    // R6: link busy, higher QoS arrives
    fwd(3'b100, 0, 4'd2, 3'b111, 1'b0, 1'b0);
    check({1'b0, fwd_gnt}, 4'b0100, "R6 AR granted");
    fwd(3'b110, 4'd15, 4'd2, 3'b111, 1'b0, 1'b0);
    check({1'b0, fwd_gnt}, 4'b0100, "R6 AR held while busy");
    fwd(3'b110, 4'd15, 4'd2, 3'b111, 1'b0, 1'b1);
    check({1'b0, fwd_gnt}, 4'b0100, "R6 AR accepted");
    fwd(3'b000, 0, 0, 3'b111, 1'b0, 1'b1);
    check({1'b0, fwd_gnt}, 4'b0000, "R9 idle after hold");

    // R7: multi-word AR beat
    fwd(3'b100, 0, 4'd1, 3'b011, 1'b0, 1'b1);
    check({1'b0, fwd_gnt}, 4'b0100, "R7 AR first word");
    fwd(3'b110, 4'd15, 4'd1, 3'b011, 1'b0, 1'b1);
    check({1'b0, fwd_gnt}, 4'b0100, "R7 AR mid beat");
    fwd(3'b110, 4'd15, 4'd1, 3'b111, 1'b0, 1'b1);
    check({1'b0, fwd_gnt}, 4'b0100, "R7 AR last word");
    fwd(3'b010, 4'd15, 0, 3'b111, 1'b0, 1'b1);
    check({1'b0, fwd_gnt}, 4'b0010, "R7 AW after beat");
    fwd(3'b001, 0, 0, 3'b111, 1'b1, 1'b1);
    check({1'b0, fwd_gnt}, 4'b0001, "R3 W pairs with AW");
    fwd(3'b000, 0, 0, 3'b111, 1'b0, 1'b1);

    // R8 R10: reverse round robin
    rev(4'b1111, 4'b1111, 1'b1); check(rev_gnt, 4'b0001, "R8 start at 0");
    rev(4'b1111, 4'b1111, 1'b1); check(rev_gnt, 4'b0010, "R8 next 1");
    rev(4'b1001, 4'b1111, 1'b1); check(rev_gnt, 4'b1000, "R8 skip to 3");
    rev(4'b1001, 4'b1111, 1'b1); check(rev_gnt, 4'b0001, "R8 wrap to 0");
    rev(4'b0000, 4'b1111, 1'b1); check(rev_gnt, 4'b0000, "R9 rev idle");
    rev(4'b0001, 4'b1111, 1'b1); check(rev_gnt, 4'b0001, "R10 single requester");
    rev(4'b1111, 4'b0000, 1'b1); check(rev_gnt, 4'b0010, "R8 ptr at 1");
    rev(4'b1111, 4'b0000, 1'b1); check(rev_gnt, 4'b0010, "R7 rev mid beat");
    rev(4'b1111, 4'b1111, 1'b1); check(rev_gnt, 4'b0010, "R7 rev last word");
    rev(4'b1111, 4'b1111, 1'b0); check(rev_gnt, 4'b0100, "R8 ptr at 2");
    rev(4'b1111, 4'b1111, 1'b0); check(rev_gnt, 4'b0100, "R6 rev held busy");
    rev(4'b1111, 4'b1111, 1'b1); check(rev_gnt, 4'b0100, "R6 rev accepted");
    rev(4'b1111, 4'b1111, 1'b1); check(rev_gnt, 4'b1000, "R8 ptr at 3");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule